// File: doc/BRIEF.md
# Global Cellular Automaton Step Engine

This block advances a global cellular automaton whose whole state lives in one 64-bit register. The state is cut into eight groups of eight cells. Each group's next value is read from its own 256-word by 8-bit lookup memory. The eight address bits of that memory come from a crossbar that can route any of the 64 current state bits to any address input. Any cell can therefore depend on any other cell, not only on its neighbours. Each group writes only its own eight bits.

The block is used in two phases. While stepping is off, a configuration port loads the crossbar selections and the lookup contents one word per cycle. A synchronous reset loads a caller-supplied initial state and restores the crossbar to its straight-through mapping. Each clock edge with the step enable high then moves all 64 cells to their next state at once. The next state is computed only from the registered current state, so there is no combinational loop.

Top module: `gca_engine`

## Requirements
- R1: A clock edge with `rst` high loads `init_state` into `state`.
- R2: After reset, crossbar output k*8+j (address bit j of lookup memory k) selects state bit k*8+j.
- R3: On each clock edge with `step_en` high and `rst` low, state bits k*8+7..k*8 take the word that lookup memory k holds at the address whose bit j is state bit sel[k*8+j], all 64 bits together, computed from the state held before that edge.
- R4: While `step_en` is low and no reset occurs, `state` keeps its value, including across configuration writes.
- R5: A write with `cfg_we`=1, `cfg_tgt`=0 and `step_en`=0 sets sel[`cfg_index`] to `cfg_data[5:0]`. It takes effect for the next step, and a select may name a bit outside its own group.
- R6: A write with `cfg_we`=1, `cfg_tgt`=1 and `step_en`=0 stores `cfg_data` at address `cfg_addr` of lookup memory `cfg_index` (0..7). Reset does not clear lookup contents.
- R7: Configuration writes of either target made while `step_en` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_state | input | 64 | State loaded on reset |
| step_en | input | 1 | Advance the automaton one generation per edge |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tgt | input | 1 | Write target: 0 crossbar select, 1 lookup memory |
| cfg_index | input | 6 | Crossbar output index, or lookup memory index |
| cfg_addr | input | 8 | Lookup memory word address |
| cfg_data | input | 8 | Lookup word, or select value in bits 5..0 |
| state | output | 64 | Current automaton state (registered) |

## Verification
Reset and every step show on `state` after exactly one rising edge. A crossbar or lookup write made at one edge shapes the step taken at the next edge. The bench drives every input 1 ns after a rising edge and samples `state` 1 ns after the following edge, so each check sees the result of exactly one edge. A bench-side model of the selects and lookup contents predicts each generation. The checks for ignored writes use reset or later steps to bring the untouched crossbar entry or lookup word back out on `state`.

// File: rtl/gca_pkg.sv
package gca_pkg;
  typedef enum logic {
    CFG_XBAR = 1'b0,
    CFG_LUT  = 1'b1
  } cfg_tgt_e;
endpackage

// File: rtl/gca_lut.sv
module gca_lut #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // asynchronous read keeps one generation per clock
  assign rdata = mem[raddr];
endmodule

// File: rtl/gca_xbar.sv
module gca_xbar #(
  parameter int N_CELLS = 64,
  parameter int XO      = 64,
  parameter int SEL_W   = $clog2(N_CELLS),
  parameter int OIW     = $clog2(XO)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_en,
  input  logic               wr_en,
  input  logic [OIW-1:0]     wr_idx,
  input  logic [SEL_W-1:0]   wr_val,
  input  logic [N_CELLS-1:0] state_in,
  output logic [XO-1:0]      addr_out
);
  function automatic logic [XO*SEL_W-1:0] ident_map();
    logic [XO*SEL_W-1:0] r;
    for (int i = 0; i < XO; i++) r[i*SEL_W +: SEL_W] = SEL_W'(i % N_CELLS);
    return r;
  endfunction

  localparam logic [XO*SEL_W-1:0] IDENT = ident_map();

  logic [SEL_W-1:0]    sel_q [XO];
  logic [XO*SEL_W-1:0] sel_flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < XO; i++) sel_q[i] <= SEL_W'(i % N_CELLS);
    end else if (wr_en) begin
      sel_q[wr_idx] <= wr_val;
    end
  end

  for (genvar g = 0; g < XO; g++) begin : g_route
    assign addr_out[g] = state_in[sel_q[g]];
    assign sel_flat[g*SEL_W +: SEL_W] = sel_q[g];
  end

  // R2: reset restores straight-through routing
  a_r2_ident_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sel_flat == IDENT);

  // R7: selects cannot change while stepping
  a_r7_sel_locked: assert property (@(posedge clk) disable iff (rst)
    step_en |=> $stable(sel_flat));
endmodule

// File: rtl/gca_engine.sv
module gca_engine #(
  parameter int  N_LUT  = 8,
  parameter int  LUT_AW = 8,
  parameter int  LUT_DW = 8,
  localparam int N_CELLS = N_LUT * LUT_DW,
  localparam int XO      = N_LUT * LUT_AW,
  localparam int SEL_W   = $clog2(N_CELLS),
  localparam int IDX_W   = $clog2(XO),
  localparam int CFG_DW  = (LUT_DW > SEL_W) ? LUT_DW : SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CELLS-1:0] init_state,
  input  logic               step_en,
  input  logic               cfg_we,
  input  logic               cfg_tgt,
  input  logic [IDX_W-1:0]   cfg_index,
  input  logic [LUT_AW-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_data,
  output logic [N_CELLS-1:0] state
);
  import gca_pkg::*;

  logic [N_CELLS-1:0] state_q;
  logic [N_CELLS-1:0] next_state;
  logic [XO-1:0]      xbar_addr;
  logic               cfg_open;
  logic               xbar_we;
  logic               lut_wr;

  assign cfg_open = cfg_we && !step_en && !rst;
  assign xbar_we  = cfg_open && (cfg_tgt == CFG_XBAR);
  assign lut_wr   = cfg_open && (cfg_tgt == CFG_LUT);

  gca_xbar #(
    .N_CELLS(N_CELLS),
    .XO     (XO),
    .SEL_W  (SEL_W),
    .OIW    (IDX_W)
  ) u_xbar (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .wr_en   (xbar_we),
    .wr_idx  (cfg_index),
    .wr_val  (cfg_data[SEL_W-1:0]),
    .state_in(state_q),
    .addr_out(xbar_addr)
  );

  for (genvar k = 0; k < N_LUT; k++) begin : g_lut
    logic we_k;
    assign we_k = lut_wr && (cfg_index == IDX_W'(k));

    gca_lut #(
      .AW(LUT_AW),
      .DW(LUT_DW)
    ) u_lut (
      .clk  (clk),
      .we   (we_k),
      .waddr(cfg_addr),
      .wdata(cfg_data[LUT_DW-1:0]),
      .raddr(xbar_addr[k*LUT_AW +: LUT_AW]),
      .rdata(next_state[k*LUT_DW +: LUT_DW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)          state_q <= init_state;
    else if (step_en) state_q <= next_state;
  end

  assign state = state_q;

  // R1: reset edge loads the supplied initial state
  a_r1_reset_load: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state == $past(init_state));

  // R4: no step, no change
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(state));
endmodule

// File: tb/tb_gca_engine.sv
module tb_gca_engine;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] init_state;
  logic        step_en;
  logic        cfg_we;
  logic        cfg_tgt;
  logic [5:0]  cfg_index;
  logic [7:0]  cfg_addr;
  logic [7:0]  cfg_data;
  logic [63:0] state;

  int tests = 0;
  int fails = 0;

  logic [7:0]  lm [8][256];
  logic [5:0]  sm [64];
  logic [63:0] ms;

  always #2 clk = ~clk;

  gca_engine dut (
    .clk(clk), .rst(rst), .init_state(init_state), .step_en(step_en),
    .cfg_we(cfg_we), .cfg_tgt(cfg_tgt), .cfg_index(cfg_index),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .state(state)
  );

  function automatic logic [7:0] fgen(int k, int a);
    return 8'((a * 37 + k * 11) ^ 8'h6C);
  endfunction

  function automatic logic [63:0] model_next(logic [63:0] s);
    logic [63:0] n;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] a;
      for (int j = 0; j < 8; j++) a[j] = s[sm[k*8+j]];
      n[k*8 +: 8] = lm[k][a];
    end
    return n;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(logic [63:0] init);
    rst = 1'b1; init_state = init; step_en = 1'b0;
    tick();
    rst = 1'b0;
    ms = init;
    for (int i = 0; i < 64; i++) sm[i] = 6'(i);
    check("R1 reset load", state, init);
  endtask

  task automatic cfg_lut(int k, int a, logic [7:0] d);
    cfg_we = 1'b1; cfg_tgt = 1'b1; cfg_index = 6'(k); cfg_addr = 8'(a); cfg_data = d;
    tick();
    cfg_we = 1'b0;
    lm[k][a] = d;
  endtask

  task automatic cfg_sel(int i, int v);
    cfg_we = 1'b1; cfg_tgt = 1'b0; cfg_index = 6'(i); cfg_addr = 8'h00; cfg_data = 8'(v);
    tick();
    cfg_we = 1'b0;
    sm[i] = 6'(v);
  endtask

  task automatic do_step(string tag);
    step_en = 1'b1;
    tick();
    step_en = 1'b0;
    ms = model_next(ms);
    check(tag, state, ms);
  endtask

  task automatic t_program_and_identity();
    do_reset(64'h0123_4567_89AB_CDEF);
    for (int k = 0; k < 8; k++)
      for (int a = 0; a < 256; a++) cfg_lut(k, a, fgen(k, a));
    check("R4 state held through lookup writes", state, ms);
    do_step("R2 identity routing step");
  endtask

  task automatic t_hold();
    for (int n = 0; n < 4; n++) begin
      tick();
      check("R4 idle hold", state, ms);
    end
  endtask

  task automatic t_multi_step();
    do_reset(64'hFFFF_0000_A5A5_1234);
    for (int n = 0; n < 6; n++) do_step("R3 consecutive steps");
  endtask

  task automatic t_xbar_permute();
    for (int i = 0; i < 64; i++) cfg_sel(i, (i * 7 + 3) % 64);
    check("R4 state held through select writes", state, ms);
    for (int n = 0; n < 5; n++) do_step("R5 permuted crossbar step");
  endtask

  task automatic t_sel_write_while_step();
    for (int j = 0; j < 8; j++) begin
      step_en = 1'b1;
      cfg_we = 1'b1; cfg_tgt = 1'b0; cfg_index = 6'(j); cfg_data = 8'd63;
      tick();
      cfg_we = 1'b0;
      ms = model_next(ms);
      check("R7 select write during step", state, ms);
    end
    step_en = 1'b0;
    for (int n = 0; n < 4; n++) do_step("R7 selects unchanged afterwards");
  endtask

  task automatic t_lut_write_while_step();
    do_reset({8{8'h33}});
    step_en = 1'b1;
    cfg_we = 1'b1; cfg_tgt = 1'b1; cfg_index = 6'd0; cfg_addr = 8'h33;
    cfg_data = ~fgen(0, 8'h33);
    tick();
    cfg_we = 1'b0; step_en = 1'b0;
    ms = model_next(ms);
    check("R7 lookup write during step", state, ms);
    do_reset({8{8'h33}});
    do_step("R7 lookup word unchanged");
  endtask

  task automatic t_lut_write();
    cfg_lut(0, 8'h33, 8'hC3);
    do_reset({8{8'h33}});
    do_step("R6 lookup write then step");
    check("R6 rewritten word in group 0", {56'd0, state[7:0]}, 64'hC3);
  endtask

  initial begin
    rst = 1'b1; init_state = '0; step_en = 1'b0;
    cfg_we = 1'b0; cfg_tgt = 1'b0; cfg_index = '0; cfg_addr = '0; cfg_data = '0;
    tick(); tick();
    t_program_and_identity();
    t_hold();
    t_multi_step();
    t_xbar_permute();
    t_sel_write_while_step();
    t_lut_write_while_step();
    t_lut_write();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule